// File: doc/BRIEF.md
# Bus-Matching Word Unpacker with Byte Reordering

This block takes 36-bit words from a first-word-fall-through FIFO and hands them to a narrower downstream consumer. Each word is four 9-bit bytes. Two size-select inputs choose the transfer size: the whole word in one transfer, two 18-bit halves, or four 9-bit bytes. Two swap-select inputs can reorder the four bytes before the word is split. The downstream side uses a ready/valid handshake, and the block marks the final piece of each word.

The block holds one word at a time. It pops the FIFO only when no word is held, or in the same cycle that the final piece of the held word is accepted. It captures the size and swap settings at that pop, so later changes to those inputs cannot disturb a word that is already being sent. Narrow pieces appear in the low bits of the output bus, and the unused upper bits read as zero.

Top module: `word_unpacker`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0. With the FIFO empty, `fifo_rd` is also 0.
- R2: Size code 00 sends the word as a single transfer. `out_data` carries all 36 reordered bits and `out_last` is 1.
- R3: Size code 01 sends two transfers. The first carries reordered bits [17:0] in `out_data[17:0]`, the second carries reordered bits [35:18], and `out_data[35:18]` is zero in both. `out_last` is 1 only on the second transfer.
- R4: Size codes 10 and 11 send four transfers. Transfer k carries reordered byte k (bits 9k+8:9k) in `out_data[8:0]`, with all other bits zero. `out_last` is 1 only on the fourth transfer.
- R5: Swap code 00 leaves the byte order unchanged: output byte i is input byte i, where byte i occupies bits 9i+8:9i.
- R6: Swap code 01 reverses the byte order: output byte i is input byte 3-i.
- R7: Swap code 10 exchanges the two 18-bit halves: output byte i is input byte i XOR 2.
- R8: Swap code 11 exchanges the two bytes within each half: output byte i is input byte i XOR 1.
- R9: `size_sel` and `swap_sel` are captured when a word is popped. Changing them while that word is being sent does not alter any of its pieces.
- R10: `fifo_rd` is asserted only when `fifo_empty` is 0 and either no word is held or the final piece is accepted in that same cycle.
- R11: `out_valid` stays low when no word is held. While a piece is stalled (`out_valid` high, `out_ready` low), `out_data` and `out_last` hold steady. Once a non-final piece is accepted, the next piece is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 2 | Transfer size: 00 full word, 01 halves, 1x bytes |
| swap_sel | input | 2 | Byte reorder code (see R5 to R8) |
| fifo_empty | input | 1 | FIFO has no word available |
| fifo_rdata | input | 36 | Word at the FIFO head (fall-through) |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| out_ready | input | 1 | Consumer accepts the current piece |
| out_valid | output | 1 | A piece is presented |
| out_data | output | 36 | Piece, right-aligned, upper bits zero |
| out_last | output | 1 | Piece is the final one of its word |

## Verification
The bench builds the block with its default byte width of 9, so the word is 36 bits. At that width it can compute every one of the sixteen size-and-swap combinations directly from the requirement equations. The bench drives each word's settings only until that word is popped, then moves them on to the next word's values, or to arbitrary values once the FIFO is empty. This exposes any late sampling of the settings. Running with three consumer patterns (always ready, alternating, pseudo-random) places pops both on the final-piece acceptance cycle and on idle cycles, and exercises stalls on every piece position.

// File: rtl/wu_pkg.sv
// Shared definitions for the word unpacker.
// Assumes four bytes per word; the swap codes depend on that count.
package wu_pkg;

    localparam int NBYTES = 4;

    typedef enum logic [1:0] {
        SZ_WORD  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_BYTE  = 2'b10,
        SZ_BYTEB = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        SW_KEEP   = 2'b00,
        SW_REV    = 2'b01,
        SW_HALVES = 2'b10,
        SW_INNER  = 2'b11
    } swap_e;

    // Index of the final piece for a size code.
    function automatic logic [1:0] final_index(input logic [1:0] sz);
        case (sz)
            SZ_WORD: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/wu_byte_swap.sv
// Reorders the four bytes of a word according to a 2-bit swap code.
// Purely combinational. Assumes exactly four bytes per word.
module wu_byte_swap #(
    parameter int BYTE_W = 9,
    localparam int WORD_W = wu_pkg::NBYTES * BYTE_W
) (
    input  logic [1:0]        swap_code,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    import wu_pkg::*;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [1:0] src;

        // Pick the source byte for this output lane.
        always_comb begin
            case (swap_e'(swap_code))
                SW_KEEP:   src = 2'(i);
                SW_REV:    src = 2'(NBYTES - 1 - i);
                SW_HALVES: src = 2'(i) ^ 2'b10;
                default:   src = 2'(i) ^ 2'b01;
            endcase
        end

        assign dout[i*BYTE_W +: BYTE_W] = din[int'(src)*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/wu_piece_ctrl.sv
// Sequences the pieces of the held word and decides when to pop the FIFO.
// Assumes a fall-through FIFO: the head word is valid whenever it is not empty.
module wu_piece_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [1:0] size_in,
    input  logic       out_ready,
    output logic       hold_valid,
    output logic [1:0] idx,
    output logic [1:0] size_q,
    output logic       load,
    output logic       piece_last
);
    import wu_pkg::*;

    logic accept;
    logic finish;

    // Handshake and pop decisions.
    always_comb begin
        piece_last = (idx == final_index(size_q));
        accept     = hold_valid && out_ready;
        finish     = accept && piece_last;
        load       = (!hold_valid || finish) && !fifo_empty;
    end

    // Holding flag, piece counter and captured size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            idx        <= 2'd0;
            size_q     <= 2'd0;
        end else if (load) begin
            hold_valid <= 1'b1;
            idx        <= 2'd0;
            size_q     <= size_in;
        end else if (finish) begin
            hold_valid <= 1'b0;
            idx        <= 2'd0;
        end else if (accept) begin
            idx <= idx + 2'd1;
        end
    end

endmodule

// File: rtl/wu_piece_mux.sv
// Selects the current piece of the held word, right-aligned, upper bits zero.
// Purely combinational.
module wu_piece_mux #(
    parameter int BYTE_W = 9,
    localparam int WORD_W = wu_pkg::NBYTES * BYTE_W,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [1:0]        size_q,
    input  logic [1:0]        idx,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] piece
);
    import wu_pkg::*;

    // Slice by transfer size and piece index.
    always_comb begin
        piece = '0;
        case (size_e'(size_q))
            SZ_WORD: piece = word;
            SZ_HALF: piece[HALF_W-1:0] = idx[0] ? word[WORD_W-1:HALF_W]
                                                : word[HALF_W-1:0];
            default: piece[BYTE_W-1:0] = word[int'(idx)*BYTE_W +: BYTE_W];
        endcase
    end

endmodule

// File: rtl/word_unpacker.sv
// Top level: pops FIFO words, reorders their bytes, and sends them as
// one, two or four pieces over a ready/valid port.
// Assumes size_sel/swap_sel are meaningful only in the cycle fifo_rd is high.
module word_unpacker #(
    parameter int BYTE_W = 9,
    localparam int WORD_W = wu_pkg::NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        size_sel,
    input  logic [1:0]        swap_sel,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] word_q;
    logic              hold_valid;
    logic [1:0]        idx;
    logic [1:0]        size_q;
    logic              load;
    logic              piece_last;

    wu_byte_swap #(.BYTE_W(BYTE_W)) u_swap (
        .swap_code (swap_sel),
        .din       (fifo_rdata),
        .dout      (swapped)
    );

    wu_piece_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .size_in    (size_sel),
        .out_ready  (out_ready),
        .hold_valid (hold_valid),
        .idx        (idx),
        .size_q     (size_q),
        .load       (load),
        .piece_last (piece_last)
    );

    // Capture the reordered word on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (load)
            word_q <= swapped;
    end

    wu_piece_mux #(.BYTE_W(BYTE_W)) u_mux (
        .size_q (size_q),
        .idx    (idx),
        .word   (word_q),
        .piece  (out_data)
    );

    assign fifo_rd   = load;
    assign out_valid = hold_valid;
    assign out_last  = hold_valid && piece_last;

endmodule

// File: rtl/wu_checker.sv
// Port-level protocol properties for word_unpacker, attached by bind.
module wu_checker #(
    parameter int BYTE_W = 9,
    localparam int WORD_W = 4 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic              out_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty); // R10

    AST_POP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |-> !fifo_rd); // R10

    AST_POP_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> out_valid); // R11

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R11

    AST_NO_GAP_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid); // R11

endmodule

bind word_unpacker wu_checker #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_word_unpacker.sv
`timescale 1ns/1ps
module sim_word_unpacker;

    localparam int BW = 9;
    localparam int WW = 4 * BW;

    typedef struct {
        logic [WW-1:0] d;
        logic [1:0]    sz;
        logic [1:0]    sw;
    } ent_t;

    typedef struct {
        logic [WW-1:0] d;
        logic          l;
        string         tag;
    } piece_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [1:0]    size_sel = 0;
    logic [1:0]    swap_sel = 0;
    logic          fifo_empty = 1;
    logic [WW-1:0] fifo_rdata = 0;
    logic          fifo_rd;
    logic          out_ready = 0;
    logic          out_valid;
    logic [WW-1:0] out_data;
    logic          out_last;

    int nchk = 0;
    int nfail = 0;
    int rmode = 0;
    bit do_pop = 0;
    bit stall_prev = 0;
    logic [WW-1:0] stall_d;
    logic          stall_l;
    bit tick = 0;

    ent_t   src[$];
    piece_t exq[$];

    always #2.5 clk = ~clk;

    word_unpacker #(.BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .swap_sel(swap_sel),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    function automatic string swap_tag(input logic [1:0] sw);
        case (sw)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Scoreboard push: expected pieces of a popped word.
    function automatic void expect_word(input ent_t e);
        logic [WW-1:0] s;
        piece_t p;
        string t;
        for (int i = 0; i < 4; i++) begin
            int k;
            case (e.sw)
                2'd0: k = i;
                2'd1: k = 3 - i;
                2'd2: k = i ^ 2;
                default: k = i ^ 1;
            endcase
            s[i*BW +: BW] = e.d[k*BW +: BW];
        end
        t = swap_tag(e.sw);
        if (e.sz == 2'd0) begin
            p.d = s; p.l = 1'b1; p.tag = {"R2/", t, "/R9"}; exq.push_back(p);
        end else if (e.sz == 2'd1) begin
            for (int h = 0; h < 2; h++) begin
                p.d = '0; p.d[2*BW-1:0] = s[h*2*BW +: 2*BW];
                p.l = (h == 1); p.tag = {"R3/", t, "/R9"}; exq.push_back(p);
            end
        end else begin
            for (int b = 0; b < 4; b++) begin
                p.d = '0; p.d[BW-1:0] = s[b*BW +: BW];
                p.l = (b == 3); p.tag = {"R4/", t, "/R9"}; exq.push_back(p);
            end
        end
    endfunction

    task automatic push_word(input logic [1:0] sz, input logic [1:0] sw);
        ent_t e;
        e.d  = {4'(sz * 4 + sw), 32'($urandom)};
        e.sz = sz;
        e.sw = sw;
        src.push_back(e);
    endtask

    // Driver and monitor, once per falling edge.
    task automatic agent();
        if (!rst_n) begin
            fifo_empty = 1; out_ready = 0; do_pop = 0; stall_prev = 0;
            return;
        end
        if (do_pop) expect_word(src.pop_front());
        if (src.size() > 0) begin
            fifo_empty = 0; fifo_rdata = src[0].d;
            size_sel = src[0].sz; swap_sel = src[0].sw;
        end else begin
            fifo_empty = 1; fifo_rdata = {4'h0, 32'($urandom)};
            size_sel = 2'($urandom); swap_sel = 2'($urandom);
        end
        case (rmode)
            0: out_ready = 1;
            1: begin tick = ~tick; out_ready = tick; end
            default: out_ready = 1'($urandom);
        endcase
        #1;
        if (stall_prev) begin
            nchk++;
            if (!out_valid || out_data !== stall_d || out_last !== stall_l) begin
                nfail++;
                $display("FAIL R11 stall hold: act v=%0b d=%h l=%0b exp v=1 d=%h l=%0b",
                         out_valid, out_data, out_last, stall_d, stall_l);
            end
        end
        do_pop = fifo_rd;
        if (fifo_rd) begin
            nchk++;
            if (fifo_empty || !(exq.size() == 0 ||
                (exq.size() == 1 && out_valid && out_ready))) begin
                nfail++;
                $display("FAIL R10 pop: act fifo_rd=1 exp 0 (empty=%0b pending=%0d)",
                         fifo_empty, exq.size());
            end
        end
        if (out_valid && out_ready) begin
            nchk++;
            if (exq.size() == 0) begin
                nfail++;
                $display("FAIL R11 unexpected piece: act d=%h exp none", out_data);
            end else begin
                piece_t p = exq.pop_front();
                if (out_data !== p.d || out_last !== p.l) begin
                    nfail++;
                    $display("FAIL %s act d=%h l=%0b exp d=%h l=%0b",
                             p.tag, out_data, out_last, p.d, p.l);
                end
            end
        end
        stall_prev = out_valid && !out_ready;
        stall_d = out_data;
        stall_l = out_last;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            agent();
        end
    end

    task automatic drain_and_idle();
        int guard = 0;
        do begin
            @(negedge clk); #2;
            guard++;
        end while ((src.size() != 0 || exq.size() != 0 || do_pop) && guard < 5000);
        repeat (4) begin
            @(negedge clk); #2;
            nchk++;
            if (out_valid !== 1'b0) begin
                nfail++;
                $display("FAIL R11 idle valid: act %0b exp 0", out_valid);
            end
        end
    endtask

    task automatic load_all();
        for (int sz = 0; sz < 4; sz++)
            for (int sw = 0; sw < 4; sw++)
                push_word(2'(sz), 2'(sw));
        // Back-to-back words with alternating settings for R9.
        for (int n = 0; n < 6; n++)
            push_word(2'(n % 3), 2'(3 - (n % 4)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        nchk++;
        if (out_valid !== 1'b0 || fifo_rd !== 1'b0) begin
            nfail++;
            $display("FAIL R1 in reset: act v=%0b rd=%0b exp 0 0", out_valid, fifo_rd);
        end
        @(negedge clk); rst_n = 1;
        @(negedge clk); #2;
        nchk++;
        if (out_valid !== 1'b0 || fifo_rd !== 1'b0) begin
            nfail++;
            $display("FAIL R1 after reset: act v=%0b rd=%0b exp 0 0", out_valid, fifo_rd);
        end
        for (int m = 0; m < 3; m++) begin
            rmode = m;
            load_all();
            drain_and_idle();
        end
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: act running exp finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule